// File: doc/BRIEF.md
# Pipeline Exception Flush Controller

This block steers a five-stage in-order pipeline when an instruction in the execute stage raises an arithmetic overflow. In the same cycle that the execute stage flags the overflow, the block performs four actions. It turns the fetched instruction into a nop by clearing the fetch/decode register contents. It zeroes the control word of the instruction being decoded. It zeroes the control word of the faulting instruction, so that the instruction never writes its destination register. It points the next program counter at a fixed handler vector. On the following clock edge, the return address (the faulting instruction's PC+4) is latched into an exception program counter.

The same block also resolves the next-PC choice for taken branches and for load-use stalls. A branch flushes only the fetched instruction, and the branch itself completes. A stall freezes the PC and the fetch/decode register and inserts a bubble into the decode/execute register. All pins are plain control and data levels, sampled every cycle, with no handshake. The only stateful element is the exception program counter. Every other output is a combinational function of the current inputs.

Top module: `exc_flush_ctrl`

## Requirements
- R1: When `ex_ovf_i` is high, `pc_sel_o` is 2'b10 and `pc_next_o` equals the parameter `HANDLER_VEC` (default 32'h8000_0180), whatever the branch and stall inputs are, and `pc_we_o` is 1.
- R2: When `br_taken_i` is high and both `ex_ovf_i` and `hz_stall_i` are low, `pc_sel_o` is 2'b01 and `pc_next_o` equals `br_target_i`.
- R3: When none of overflow, stall or taken branch applies, `pc_sel_o` is 2'b00 and `pc_next_o` equals `pc_i + 4`, wrapping modulo 2^32.
- R4: `if_flush_o` is high exactly when an overflow occurs or a branch is taken without a stall. While it is high, `ifid_instr_o` and `ifid_pc4_o` are zero. Otherwise they pass `fetch_instr_i` and `pc_i + 4` through unchanged.
- R5: `id_flush_o` equals the OR of `ex_ovf_i` and `hz_stall_i`. While it is high, `idex_ctrl_o` is zero. Otherwise it equals `dec_ctrl_i`.
- R6: `ex_flush_o` is high only when `ex_ovf_i` is high, so a taken branch never flushes the execute stage. While `ex_flush_o` is high, `exmem_ctrl_o` is zero, which suppresses the faulting instruction's writeback. Otherwise `exmem_ctrl_o` equals `ex_ctrl_i`.
- R7: A stall without an overflow drives `pc_we_o` and `ifid_we_o` to 0. During such a stall a taken branch is ignored: `pc_sel_o` stays 2'b00 and `if_flush_o` stays 0. In all other cases both enables are 1.
- R8: `epc_o` resets to zero. On each rising clock edge where `ex_ovf_i` is high, it loads `ex_pc4_i`. On any other edge it holds its value. For example, an overflowing add at 0x4C leaves 0x50.
- R9: The select code 2'b11 never appears on `pc_sel_o`. Inside the next-PC multiplexer, that code is treated as the handler vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ex_ovf_i | input | 1 | Overflow flag from the execute stage |
| br_taken_i | input | 1 | Branch compare result (branch resolved and taken) |
| hz_stall_i | input | 1 | Load-use stall request from hazard detection |
| pc_i | input | 32 | Current program counter |
| br_target_i | input | 32 | Branch target address |
| ex_pc4_i | input | 32 | PC+4 of the instruction in the execute stage |
| fetch_instr_i | input | 32 | Instruction word being fetched |
| dec_ctrl_i | input | 10 | Control word produced by the decoder |
| ex_ctrl_i | input | 5 | Control word held in the decode/execute register for the memory and writeback stages |
| if_flush_o | output | 1 | Fetch-stage flush |
| id_flush_o | output | 1 | Decode-stage flush |
| ex_flush_o | output | 1 | Execute-stage flush |
| pc_sel_o | output | 2 | Next-PC select: 00 sequential, 01 branch, 10 exception |
| pc_next_o | output | 32 | Next program counter value |
| pc_we_o | output | 1 | PC register write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| ifid_instr_o | output | 32 | Instruction to load into the fetch/decode register |
| ifid_pc4_o | output | 32 | PC+4 to load into the fetch/decode register |
| idex_ctrl_o | output | 10 | Control word to load into the decode/execute register |
| exmem_ctrl_o | output | 5 | Control word to load into the execute/memory register |
| epc_o | output | 32 | Exception program counter |

## Verification
The bench sweeps every combination of overflow, branch and stall across four data patterns, one of which makes PC+4 wrap past 2^32.

Three corner cases get particular attention. The first is overflow arriving together with a branch and a stall. A design with the priority reversed would jump to the branch target, or freeze the PC, and so lose the exception. The second is a taken branch on its own. A design that also flushed the execute stage would silently drop the branch's own writeback. The third is a branch during a stall. A design that honoured it would redirect fetch off a stale compare.

The faulting-add sequence at 0x40 to 0x54 then checks three outcomes: that EPC holds 0x50 and not 0x4C, that the add, slt and lw all turn into bubbles, and that the next fetch address is the handler vector.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    PCS_SEQ = 2'b00,
    PCS_BR  = 2'b01,
    PCS_EXC = 2'b10
  } pc_src_e;

  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/exc_pc_select.sv
module exc_pc_select
  import exc_pkg::*;
#(
  parameter int unsigned  XLEN        = 32,
  parameter logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0180
) (
  input  logic            ovf,
  input  logic            br_taken,
  input  logic            stall,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] br_target,
  output logic [1:0]      sel,
  output logic [XLEN-1:0] pc_seq,
  output logic [XLEN-1:0] pc_next,
  output logic            pc_we,
  output logic            br_eff
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  // A branch is honoured only when the stage holding it is not stalled.
  assign br_eff = br_taken & ~stall;
  assign pc_seq = pc + STEP;

  // Exception wins over branch.
  always_comb begin
    if (ovf)         sel = PCS_EXC;
    else if (br_eff) sel = PCS_BR;
    else             sel = PCS_SEQ;
  end

  // Four-way multiplexer; the spare code aliases onto the vector.
  always_comb begin
    case (sel)
      2'b00:   pc_next = pc_seq;
      2'b01:   pc_next = br_target;
      default: pc_next = HANDLER_VEC;
    endcase
  end

  assign pc_we = ovf | ~stall;
endmodule

// File: rtl/exc_bubble_gate.sv
module exc_bubble_gate #(
  parameter int unsigned W = 8
) (
  input  logic         kill,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  assign q = kill ? '0 : d;
endmodule

// File: rtl/exc_epc_reg.sv
module exc_epc_reg #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [XLEN-1:0] ret_addr,
  output logic [XLEN-1:0] epc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       epc <= '0;
    else if (capture) epc <= ret_addr;
  end

  AST_EPC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> epc == $past(ret_addr)); // R8
  AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(epc)); // R8
endmodule

// File: rtl/exc_flush_ctrl.sv
module exc_flush_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN        = 32,
  parameter int unsigned     IDEX_CW     = 10,
  parameter int unsigned     EXMEM_CW    = 5,
  parameter logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0180
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ex_ovf_i,
  input  logic                br_taken_i,
  input  logic                hz_stall_i,
  input  logic [XLEN-1:0]     pc_i,
  input  logic [XLEN-1:0]     br_target_i,
  input  logic [XLEN-1:0]     ex_pc4_i,
  input  logic [XLEN-1:0]     fetch_instr_i,
  input  logic [IDEX_CW-1:0]  dec_ctrl_i,
  input  logic [EXMEM_CW-1:0] ex_ctrl_i,
  output logic                if_flush_o,
  output logic                id_flush_o,
  output logic                ex_flush_o,
  output logic [1:0]          pc_sel_o,
  output logic [XLEN-1:0]     pc_next_o,
  output logic                pc_we_o,
  output logic                ifid_we_o,
  output logic [XLEN-1:0]     ifid_instr_o,
  output logic [XLEN-1:0]     ifid_pc4_o,
  output logic [IDEX_CW-1:0]  idex_ctrl_o,
  output logic [EXMEM_CW-1:0] exmem_ctrl_o,
  output logic [XLEN-1:0]     epc_o
);
  localparam int unsigned IFID_W = 2 * XLEN;

  logic            br_eff;
  logic [XLEN-1:0] pc_seq;
  logic [IFID_W-1:0] ifid_q;

  exc_pc_select #(.XLEN(XLEN), .HANDLER_VEC(HANDLER_VEC)) u_sel (
    .ovf(ex_ovf_i), .br_taken(br_taken_i), .stall(hz_stall_i),
    .pc(pc_i), .br_target(br_target_i), .sel(pc_sel_o),
    .pc_seq(pc_seq), .pc_next(pc_next_o), .pc_we(pc_we_o), .br_eff(br_eff)
  );

  // Flush lines: fetch on exception or redirecting branch, decode on
  // exception or stall, execute only on exception.
  assign if_flush_o = ex_ovf_i | br_eff;
  assign id_flush_o = ex_ovf_i | hz_stall_i;
  assign ex_flush_o = ex_ovf_i;
  assign ifid_we_o  = pc_we_o;

  // Fetch/decode carries no control bits, so the whole payload is cleared.
  exc_bubble_gate #(.W(IFID_W)) u_ifid (
    .kill(if_flush_o), .d({fetch_instr_i, pc_seq}), .q(ifid_q)
  );
  assign ifid_instr_o = ifid_q[IFID_W-1:XLEN];
  assign ifid_pc4_o   = ifid_q[XLEN-1:0];

  exc_bubble_gate #(.W(IDEX_CW)) u_idex (
    .kill(id_flush_o), .d(dec_ctrl_i), .q(idex_ctrl_o)
  );
  exc_bubble_gate #(.W(EXMEM_CW)) u_exmem (
    .kill(ex_flush_o), .d(ex_ctrl_i), .q(exmem_ctrl_o)
  );

  exc_epc_reg #(.XLEN(XLEN)) u_epc (
    .clk(clk), .rst_n(rst_n), .capture(ex_ovf_i),
    .ret_addr(ex_pc4_i), .epc(epc_o)
  );

  AST_EXC_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ovf_i |-> (pc_next_o == HANDLER_VEC && pc_we_o)); // R1
  AST_BRANCH_KEEPS_EX: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken_i && !ex_ovf_i) |-> (exmem_ctrl_o == ex_ctrl_i)); // R6
  AST_FAULT_KILLED: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ovf_i |-> (exmem_ctrl_o == '0 && idex_ctrl_o == '0 && ifid_instr_o == '0)); // R6
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hz_stall_i && !ex_ovf_i) |-> (!pc_we_o && !ifid_we_o && pc_sel_o == 2'b00)); // R7
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel_o != 2'b11 && $countones(pc_sel_o) <= 1); // R9
endmodule

// File: tb/sim_exc_flush_ctrl.sv
`timescale 1ns/1ps
module sim_exc_flush_ctrl;
  localparam logic [31:0] VEC = 32'h8000_0180;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovf = 0, br = 0, stall = 0;
  logic [31:0] pc = 0, tgt = 0, expc4 = 0, instr = 0;
  logic [9:0] dec = 0;
  logic [4:0] exc = 0;
  logic if_fl, id_fl, ex_fl, pc_we, ifid_we;
  logic [1:0] sel;
  logic [31:0] pc_next, ifid_instr, ifid_pc4, epc;
  logic [9:0] idex;
  logic [4:0] exmem;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_epc = 0;

  always #2.5 clk = ~clk;

  exc_flush_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ex_ovf_i(ovf), .br_taken_i(br), .hz_stall_i(stall),
    .pc_i(pc), .br_target_i(tgt), .ex_pc4_i(expc4), .fetch_instr_i(instr),
    .dec_ctrl_i(dec), .ex_ctrl_i(exc), .if_flush_o(if_fl), .id_flush_o(id_fl),
    .ex_flush_o(ex_fl), .pc_sel_o(sel), .pc_next_o(pc_next), .pc_we_o(pc_we),
    .ifid_we_o(ifid_we), .ifid_instr_o(ifid_instr), .ifid_pc4_o(ifid_pc4),
    .idex_ctrl_o(idex), .exmem_ctrl_o(exmem), .epc_o(epc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, check combinational outputs 1 ns later.
  task automatic step(input logic o, input logic b, input logic s, input logic [31:0] p,
                      input logic [31:0] t, input logic [31:0] e4, input logic [31:0] in,
                      input logic [9:0] d, input logic [4:0] x);
    logic brk;
    logic [1:0] es;
    logic [31:0] en;
    @(negedge clk);
    ovf = o; br = b; stall = s; pc = p; tgt = t; expc4 = e4; instr = in; dec = d; exc = x;
    #1;
    brk = b & ~s;
    es  = o ? 2'b10 : (brk ? 2'b01 : 2'b00);
    en  = o ? VEC : (brk ? t : p + 32'd4);
    chk("R1/R2/R3 pc_sel", {30'd0, sel}, {30'd0, es});
    chk("R1/R2/R3 pc_next", pc_next, en);
    chk("R4 if_flush", {31'd0, if_fl}, {31'd0, o | brk});
    chk("R4 ifid_instr", ifid_instr, (o | brk) ? 32'd0 : in);
    chk("R4 ifid_pc4", ifid_pc4, (o | brk) ? 32'd0 : p + 32'd4);
    chk("R5 id_flush/idex", {21'd0, id_fl, idex}, {21'd0, o | s, (o | s) ? 10'd0 : d});
    chk("R6 ex_flush/exmem", {26'd0, ex_fl, exmem}, {26'd0, o, o ? 5'd0 : x});
    chk("R7 pc_we/ifid_we", {30'd0, pc_we, ifid_we}, {30'd0, o | ~s, o | ~s});
    chk("R9 sel not 11", {31'd0, sel == 2'b11}, 32'd0);
    @(posedge clk);
    if (o) exp_epc = e4;
    #1;
    chk("R8 epc", epc, exp_epc);
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] pcs [4];
    pcs[0] = 32'h0000_0040; pcs[1] = 32'hFFFF_FFFC; pcs[2] = 32'h1234_5678; pcs[3] = 32'h7FFF_FFF0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 epc reset", epc, 32'd0);
    rst_n = 1'b1;
    // Sweep all control combinations over several data patterns.
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 8; c++) begin
        step(c[0], c[1], c[2], pcs[p], pcs[p] ^ 32'h00F0_0F00, pcs[p] + 32'h100 * (c + 1),
             ~pcs[p], 10'(10'h2A5 ^ (c * 37)), 5'(5'h1B ^ c));
      end
    end
    // Faulting sequence: sub 0x40, and 0x44, or 0x48, add 0x4C (overflows), slt 0x50, lw 0x54.
    // Cycle with add in EX: slt in ID, lw in IF at 0x54.
    step(0, 0, 0, 32'h48, 0, 32'h48, 32'h0046_6825, 10'h1F3, 5'h13);
    step(0, 0, 0, 32'h4C, 0, 32'h4C, 32'h0041_0820, 10'h1F3, 5'h13);
    step(1, 0, 0, 32'h54, 0, 32'h50, 32'h8CF0_0032, 10'h1F3, 5'h13);
    chk("R8 scenario epc 0x50", epc, 32'h50);
    // Handler now fetched, pipeline continues normally from the vector.
    step(0, 0, 0, VEC, 0, 32'h0, 32'hAC19_03E8, 10'h000, 5'h00);
    chk("R8 epc held", epc, 32'h50);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule